// File: doc/BRIEF.md
# Asynchronous SRAM bus controller

This block sits between a synchronous request port and an 8K-word by 8-bit asynchronous static RAM. The memory has two chip selects (one active low, one active high), active-low write and output enables, and one shared bidirectional data bus. Each accepted request becomes one complete pin sequence. A read holds the part selected with its output enabled until the counted access time has passed, registers the bus, and then returns the output buffers to high impedance before anything else drives the bus. A write selects the part, places the data on the bus, pulses the write enable for a counted width, and keeps the data driven one cycle past the end of the pulse.

The request side is a valid/ready port. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the requester must keep `req_valid`, `req_write`, `req_addr` and `req_wdata` steady. Only one request is in flight at a time. The response is a single-cycle `rsp_valid` pulse with no back-pressure. For reads it carries the data in `rsp_rdata`.

Every timing limit is a picosecond parameter. Each one is turned into a whole number of clock cycles by dividing by the clock period and rounding up. The data bus is modelled as a drive enable, an outgoing byte and an incoming byte, and the pad is left outside the block.

Top module: `sram_ctrl`

## Requirements
- R1: Out of reset and whenever idle, the controller holds `req_ready`=1, `mem_cs1_n`=1, `mem_cs2`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R2: For the RD cycles that follow the edge that accepts a read, the controller drives `mem_cs1_n`=0, `mem_cs2`=1, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0, with `mem_addr` equal to the request address and unchanged. RD = ceil(access time / clock period), which is 10 with the defaults.
- R3: The read data is registered from `mem_dq_in` on the RD-th edge after acceptance. `rsp_valid` is high for exactly the one following cycle, and `rsp_rdata` then holds that byte.
- R4: After a read, there are TA cycles with the part deselected, `mem_oe_n`=1, `mem_dq_oe`=0 and `req_ready`=0. TA = max(1, ceil(output-disable time / clock period)), which is 4 with the defaults.
- R5: A write runs in three phases. First comes one cycle selected with `mem_we_n`=1 and `mem_dq_oe`=1. Then come WE cycles with `mem_we_n`=0. Last comes one cycle with `mem_we_n`=1 while the part is still selected and still driven. `mem_addr` and `mem_dq_out` hold the request values throughout.
- R6: WE = max(ceil(pulse width), ceil(data setup before end of write), ceil(address valid to end of write) − 1), each in clock cycles. This is 7 with the defaults.
- R7: In the cycle after the last write phase, the controller is idle with `req_ready`=1 and `rsp_valid`=1 for that single cycle.
- R8: `req_ready` is low from the cycle after an acceptance until that access completes. Inputs presented while it is low are not taken. `rsp_valid` is never high except in the cycles named in R3 and R7.
- R9: `mem_dq_oe` is never high while `mem_oe_n` is low. It stays low for at least TA full cycles after `mem_oe_n` rises.
- R10: `mem_we_n` is low only while the part is selected, `mem_oe_n` is high and `mem_dq_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_valid after a read |
| mem_addr | output | 13 | Memory address pins |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_in | input | 8 | Byte read from the data bus |

## Verification
The bench builds the controller with its defaults: a 10 ns clock period and the 100 ns speed grade. This gives 10-cycle reads, a 7-cycle write pulse and a 4-cycle read-to-write turnaround, so every phase boundary has an exact, distinct cycle that can be checked. The memory model in the bench returns a poison byte until the output enable has been low for RD−1 completed edges. A capture one edge early therefore produces wrong data. Back-to-back writes, a write presented right after a read, and accesses at addresses 0 and 8191 cover the turnaround and ready hand-off cycles.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RACC,
    ST_TURN,
    ST_WSET,
    ST_WLOW,
    ST_WHOLD
  } st_e;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC = 10,
  parameter int unsigned WE_CYC = 7,
  parameter int unsigned TA_CYC = 4,
  parameter int unsigned CNT_W  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_wr,
  output st_e  st,
  output logic ready,
  output logic cap_en,
  output logic wr_done
);

  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            if (start_wr) begin
              st  <= ST_WSET;
              cnt <= '0;
            end else begin
              st  <= ST_RACC;
              cnt <= CNT_W'(RD_CYC - 1);
            end
          end
        end
        ST_RACC: begin
          if (cnt_zero) begin
            st  <= ST_TURN;
            cnt <= CNT_W'(TA_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_TURN: begin
          if (cnt_zero) st <= ST_IDLE;
          else          cnt <= cnt - 1'b1;
        end
        ST_WSET: begin
          st  <= ST_WLOW;
          cnt <= CNT_W'(WE_CYC - 1);
        end
        ST_WLOW: begin
          if (cnt_zero) st <= ST_WHOLD;
          else          cnt <= cnt - 1'b1;
        end
        ST_WHOLD: st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign ready   = (st == ST_IDLE);
  assign cap_en  = (st == ST_RACC) && cnt_zero;
  assign wr_done = (st == ST_WHOLD);

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  st_e               st,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cap_en,
  input  logic              wr_done,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic sel;
  logic wr_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cap_en | wr_done;
      if (cap_en) rsp_rdata <= mem_dq_in;
    end
  end

  always_comb begin
    wr_phase = (st == ST_WSET) || (st == ST_WLOW) || (st == ST_WHOLD);
    sel      = wr_phase || (st == ST_RACC);
  end

  assign mem_cs1_n = ~sel;
  assign mem_cs2   = sel;
  assign mem_oe_n  = (st != ST_RACC);
  assign mem_we_n  = (st != ST_WLOW);
  assign mem_dq_oe = wr_phase;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_PS    = 10000,
  parameter int unsigned T_ACC_PS  = 100000,
  parameter int unsigned T_WP_PS   = 60000,
  parameter int unsigned T_AW_PS   = 80000,
  parameter int unsigned T_DW_PS   = 40000,
  parameter int unsigned T_OHZ_PS  = 35000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned RD_CYC = max2(1, ceil_div(T_ACC_PS, CLK_PS));
  localparam int unsigned AW_CYC = max2(1, ceil_div(T_AW_PS, CLK_PS)) - 1;
  localparam int unsigned WE_CYC = max2(1, max2(ceil_div(T_WP_PS, CLK_PS),
                                           max2(ceil_div(T_DW_PS, CLK_PS), AW_CYC)));
  localparam int unsigned TA_CYC = max2(1, ceil_div(T_OHZ_PS, CLK_PS));
  localparam int unsigned MAX_CYC = max2(RD_CYC, max2(WE_CYC, TA_CYC));
  localparam int unsigned CNT_W  = max2(1, $clog2(MAX_CYC + 1));

  st_e  st;
  logic accept;
  logic cap_en;
  logic wr_done;

  assign accept = req_valid & req_ready;

  sram_ctrl_seq #(
    .RD_CYC(RD_CYC),
    .WE_CYC(WE_CYC),
    .TA_CYC(TA_CYC),
    .CNT_W (CNT_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .start_wr(req_write),
    .st      (st),
    .ready   (req_ready),
    .cap_en  (cap_en),
    .wr_done (wr_done)
  );

  sram_ctrl_pins #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cap_en    (cap_en),
    .wr_done   (wr_done),
    .mem_dq_in (mem_dq_in),
    .mem_addr  (mem_addr),
    .mem_cs1_n (mem_cs1_n),
    .mem_cs2   (mem_cs2),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_dq_out(mem_dq_out),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned WE_CYC = 7,
  parameter int unsigned TA_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs1_n,
  input logic              mem_cs2,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  logic [15:0] since_oe_rise;
  logic [15:0] we_low_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_oe_rise <= 16'hFFFF;
      we_low_len    <= '0;
    end else begin
      if (!mem_oe_n)                  since_oe_rise <= '0;
      else if (since_oe_rise != 16'hFFFF) since_oe_rise <= since_oe_rise + 1'b1;
      if (!mem_we_n) we_low_len <= we_low_len + 1'b1;
      else           we_low_len <= '0;
    end
  end

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe));

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr));

  assert_ack_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_we_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_len >= 16'(WE_CYC)));

  assert_busy_after_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_no_contention_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && (since_oe_rise >= 16'(TA_CYC))));

  assert_we_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs1_n && mem_cs2 && mem_oe_n && mem_dq_oe));

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .WE_CYC(WE_CYC),
  .TA_CYC(TA_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .mem_addr (mem_addr),
  .mem_cs1_n(mem_cs1_n),
  .mem_cs2  (mem_cs2),
  .mem_we_n (mem_we_n),
  .mem_oe_n (mem_oe_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctrl_tb.sv
`timescale 1ns/1ps
module sram_ctrl_tb;

  localparam int AW = 13;
  localparam int DW = 8;
  localparam int PER_PS = 10000;
  // cycle counts worked out from R2, R4, R6 for the 100 ns grade
  localparam int E_RD = (100000 + PER_PS - 1) / PER_PS;
  localparam int E_TA = (35000 + PER_PS - 1) / PER_PS;
  localparam int E_WE = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid, req_write;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out, mem_dq_in;

  always #5 clk = ~clk;

  sram_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in)
  );

  // memory model: poison until output enable has been low long enough
  logic [DW-1:0] sram   [0:(1<<AW)-1];
  logic [DW-1:0] refmem [0:(1<<AW)-1];
  int oe_age = 0;

  always @(posedge clk) oe_age <= mem_oe_n ? 0 : oe_age + 1;

  assign mem_dq_in = (!mem_cs1_n && mem_cs2 && !mem_oe_n && mem_we_n && oe_age >= E_RD - 1)
                     ? sram[mem_addr] : 8'hEE;

  always @(posedge mem_we_n)
    if (rst_n && !mem_cs1_n && mem_cs2 && mem_dq_oe) sram[mem_addr] = mem_dq_out;

  int nchk = 0;
  int nerr = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  typedef struct {
    bit          wr;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int          gap;
  } op_t;

  op_t ops[$];

  task automatic push(input bit wr, input int a, input int d, input int gap);
    op_t o;
    o.wr = wr; o.a = AW'(a); o.d = DW'(d); o.gap = gap;
    ops.push_back(o);
  endtask

  // model: kind 0 idle, 1 read, 2 write; age counts cycles since acceptance
  int kind = 0;
  int age  = 0;
  logic [AW-1:0] ea;
  logic [DW-1:0] ed, erd;

  task automatic compare();
    bit e_sel, e_we_n, e_oe_n, e_dq, e_rdy, e_rsp;
    e_sel = 0; e_we_n = 1; e_oe_n = 1; e_dq = 0; e_rdy = 0; e_rsp = 0;
    if (kind == 0) e_rdy = 1;
    else if (kind == 1) begin
      if (age <= E_RD) begin e_sel = 1; e_oe_n = 0; end
      e_rsp = (age == E_RD + 1);
    end else begin
      if (age == E_WE + 3) begin e_rdy = 1; e_rsp = 1; end
      else begin
        e_sel = 1; e_dq = 1;
        e_we_n = !(age >= 2 && age <= E_WE + 1);
      end
    end
    chk(req_ready == e_rdy, "R8", "req_ready", int'(req_ready), int'(e_rdy));
    chk(mem_cs1_n == !e_sel && mem_cs2 == e_sel, (kind == 0) ? "R1" : "R2", "select",
        int'({mem_cs1_n, mem_cs2}), int'({!e_sel, e_sel}));
    chk(mem_oe_n == e_oe_n, (kind == 1) ? "R4" : "R1", "mem_oe_n", int'(mem_oe_n), int'(e_oe_n));
    chk(mem_we_n == e_we_n, (kind == 2) ? "R6" : "R10", "mem_we_n", int'(mem_we_n), int'(e_we_n));
    chk(mem_dq_oe == e_dq, (kind == 2) ? "R5" : "R9", "mem_dq_oe", int'(mem_dq_oe), int'(e_dq));
    chk(rsp_valid == e_rsp, (kind == 2) ? "R7" : "R3", "rsp_valid", int'(rsp_valid), int'(e_rsp));
    if (e_sel) chk(mem_addr == ea, "R2", "mem_addr", int'(mem_addr), int'(ea));
    if (e_dq)  chk(mem_dq_out == ed, "R5", "mem_dq_out", int'(mem_dq_out), int'(ed));
    if (e_rsp && kind == 1) chk(rsp_rdata == erd, "R3", "rsp_rdata", int'(rsp_rdata), int'(erd));
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin
      sram[i]   = DW'(i) ^ 8'h5A;
      refmem[i] = DW'(i) ^ 8'h5A;
    end
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;

    push(1, 13'h0000, 8'hA1, 0);
    push(1, 13'h1FFF, 8'h5C, 0);   // presented while the first write is busy
    push(0, 13'h0000, 0, 0);
    push(0, 13'h1FFF, 0, 0);
    push(1, 13'h0123, 8'h3C, 0);   // write right after a read: turnaround
    push(0, 13'h0123, 0, 2);
    push(0, 13'h0456, 0, 0);       // never written: initial pattern
    push(1, 13'h0456, 8'hFF, 3);
    push(0, 13'h0456, 0, 0);
    push(1, 13'h0000, 8'h00, 0);
    push(0, 13'h0000, 0, 1);
    push(0, 13'h0AAA, 0, 0);

    repeat (3) @(negedge clk);
    // reset state
    chk(req_ready && mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
        "R1", "reset pins", int'({req_ready, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe}),
        int'(6'b110110));
    rst_n = 1'b1;

    begin
      int gapc = 0;
      while (ops.size() > 0 || kind != 0) begin
        bit rdy_e, acc;
        @(negedge clk);
        compare();
        rdy_e = (kind == 0) || (kind == 2 && age == E_WE + 3);
        acc = 0;
        if (ops.size() > 0 && gapc == 0) begin
          req_valid = 1; req_write = ops[0].wr; req_addr = ops[0].a; req_wdata = ops[0].d;
          acc = rdy_e;
        end else begin
          req_valid = 0; req_write = 1'($urandom); req_addr = AW'($urandom); req_wdata = DW'($urandom);
          if (gapc > 0) gapc--;
        end
        if (acc) begin
          ea = ops[0].a; ed = ops[0].d; age = 1;
          if (ops[0].wr) begin kind = 2; refmem[ops[0].a] = ops[0].d; end
          else begin kind = 1; erd = refmem[ops[0].a]; end
          gapc = ops[0].gap;
          void'(ops.pop_front());
        end else if (kind == 1 && age == E_RD + E_TA) kind = 0;
        else if (kind == 2 && age == E_WE + 3) kind = 0;
        else if (kind != 0) age++;
      end
      req_valid = 0;
      repeat (3) begin
        @(negedge clk);
        compare();
      end
      // final memory contents written through the pins
      chk(sram[13'h1FFF] == 8'h5C, "R5", "sram[1FFF]", int'(sram[13'h1FFF]), 8'h5C);
      chk(sram[13'h0000] == 8'h00, "R5", "sram[0000]", int'(sram[13'h0000]), 8'h00);
    end
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL R8 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule